// File: doc/BRIEF.md
# Per-Context Register-Set Call Stack

This block holds the saved register sets of a processor that runs many hardware contexts. Each context owns a small private stack of register sets. A context call copies the live register set onto the running context's stack and hands back the register set stored for a target context. The processor keeps the same context number and runs on with the borrowed registers. A context return takes the most recent entry off that stack and hands it back. Because every context has its own stack, a context switch never copies any stack.

A save command writes the live register set into the context's slot in context memory. The interrupt-enable bit of the stored copy is fixed by the context number, not taken from the live value. A fourth command performs an interrupt return and a stack pop together.

The processor drives a command with the running and target context numbers and the live register set. It loads `regs_out` whenever `regs_load` pulses. Every accepted command takes the same number of cycles.

Top module: `ctx_regstack`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `regs_load`, `irq_ret`, `ovf` and `unf` are 0, and the stack of every context is empty.
- R2: A command is accepted on a rising edge where `cmd_valid` is 1 and `busy` is 0. `busy` is then 1 for the next two cycles. In the third cycle `busy` is 0 and `done` is 1 for exactly one cycle. `regs_load`, `irq_ret`, `ovf` and `unf` can be 1 only in that `done` cycle.
- R3: A command presented while `busy` is 1 is ignored. It changes no stack and no output.
- R4: Save (`cmd_op`=00) stores `live_regs` for context `cur_ctx`, with bit 0 (interrupt enable, 1 = enabled) handled by context number. Bit 0 is forced to 0 for contexts 1 to 3. It is forced to 1 for contexts 4 and above. It is copied unchanged for context 0. All other bits are copied unchanged.
- R5: Call (`cmd_op`=01) pushes `live_regs` onto the stack of `cur_ctx`. It then puts the set last saved for `tgt_ctx` on `regs_out` and pulses `regs_load`.
- R6: Return (`cmd_op`=10) pops the stack of `cur_ctx` in last-in, first-out order. It puts the popped set on `regs_out` and pulses `regs_load`.
- R7: A call to a context whose stack already holds 8 entries is refused. `ovf` pulses, `regs_load` stays 0, and the stack keeps its 8 entries.
- R8: A return or interrupt-return on an empty stack pulses `unf`, leaves `regs_load` and `irq_ret` at 0, and changes nothing else.
- R9: Interrupt-return-and-pop (`cmd_op`=11) pops like a return and also pulses `irq_ret` in the same cycle. No other command pulses `irq_ret`.
- R10: The stacks of different contexts are independent. A push or pop on one context never changes another context's stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 save, 01 call, 10 return, 11 interrupt-return-and-pop |
| cur_ctx | input | CTX_W (8) | Running context number |
| tgt_ctx | input | CTX_W (8) | Target context of a call |
| live_regs | input | REG_W (16) | Live register set, bit 0 = interrupt enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| regs_load | output | 1 | Processor must load `regs_out` |
| regs_out | output | REG_W (16) | Register set to load |
| irq_ret | output | 1 | Interrupt return to perform |
| ovf | output | 1 | Call refused, stack full |
| unf | output | 1 | Pop refused, stack empty |

## Verification
The assertions assume that `cmd_op`, `cur_ctx`, `tgt_ctx` and `live_regs` are valid whenever `cmd_valid` is 1. They also assume that a call reads only target contexts that have been saved at least once, because context memory has no reset. The directed stimulus changes command inputs only on falling edges. It saves every target context before any call reads it. It deliberately raises `cmd_valid` during a busy window, so the ignore rule is exercised without breaking these assumptions.

// File: rtl/ctxstk_pkg.sv
// Shared types for the per-context register-set stack.
// Assumes: command code values are fixed by the port contract.
package ctxstk_pkg;

    typedef enum logic [1:0] {
        OP_SAVE = 2'b00,
        OP_CALL = 2'b01,
        OP_RET  = 2'b10,
        OP_IRET = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_READ = 2'b01,
        ST_EXEC = 2'b10
    } st_e;

endpackage

// File: rtl/ctxstk_ram.sv
// Simple dual-port memory: one synchronous write port and one registered read port.
// Assumes: the caller never reads and writes the same address in one cycle.
module ctxstk_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int N = 1 << AW;

    logic [DW-1:0] mem [N];

    // Store a word when write is enabled.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Register the read word when read is enabled.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/ctxstk_sp_table.sv
// Per-context stack pointer table. Each pointer counts 0..DEPTH entries.
// Assumes: the controller never writes a value above DEPTH.
module ctxstk_sp_table #(
    parameter int CTX_W = 8,
    parameter int DEPTH = 8,
    parameter int SP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTX_W-1:0] rd_ctx,
    output logic [SP_W-1:0]  rd_sp,
    input  logic             we,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic [SP_W-1:0]  wr_sp
);
    localparam int NCTX = 1 << CTX_W;

    logic [SP_W-1:0] sp_q [NCTX];

    // Clear all pointers on reset, otherwise update the addressed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCTX; i++) sp_q[i] <= '0;
        end else if (we) begin
            sp_q[wr_ctx] <= wr_sp;
        end
    end

    // Read the pointer of the requested context.
    assign rd_sp = sp_q[rd_ctx];

    p_sp_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wr_sp <= SP_W'(DEPTH)));
endmodule

// File: rtl/ctxstk_ie_force.sv
// Fixes the interrupt-enable bit of a register set that is being saved:
// 0 for contexts 1..RT_LAST, 1 above RT_LAST, and copied unchanged for context 0.
// Assumes: IE_POS is a valid bit index of the register set.
module ctxstk_ie_force #(
    parameter int CTX_W   = 8,
    parameter int REG_W   = 16,
    parameter int IE_POS  = 0,
    parameter int RT_LAST = 3
) (
    input  logic [CTX_W-1:0] ctx,
    input  logic [REG_W-1:0] regs_in,
    output logic [REG_W-1:0] regs_fixed
);
    // Select the stored interrupt-enable value by context number.
    always_comb begin
        regs_fixed = regs_in;
        if (ctx == '0)
            regs_fixed[IE_POS] = regs_in[IE_POS];
        else if (ctx <= CTX_W'(RT_LAST))
            regs_fixed[IE_POS] = 1'b0;
        else
            regs_fixed[IE_POS] = 1'b1;
    end
endmodule

// File: rtl/ctx_regstack.sv
// Per-context register-set call stack controller.
// Runs save, call, return and interrupt-return-and-pop commands in three cycles:
// accept, memory read, execute. Results are registered and appear with done.
// Assumes: DEPTH is a power of two; inputs are stable while cmd_valid is high.
module ctx_regstack #(
    parameter int CTX_W   = 8,
    parameter int REG_W   = 16,
    parameter int DEPTH   = 8,
    parameter int IE_POS  = 0,
    parameter int RT_LAST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [CTX_W-1:0] cur_ctx,
    input  logic [CTX_W-1:0] tgt_ctx,
    input  logic [REG_W-1:0] live_regs,
    output logic             busy,
    output logic             done,
    output logic             regs_load,
    output logic [REG_W-1:0] regs_out,
    output logic             irq_ret,
    output logic             ovf,
    output logic             unf
);
    import ctxstk_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);
    localparam int SP_W  = PTR_W + 1;
    localparam int SAW   = CTX_W + PTR_W;

    st_e              state;
    op_e              op_q;
    logic [CTX_W-1:0] cur_q, tgt_q;
    logic [REG_W-1:0] live_q, live_fixed, ctx_rd, stk_rd;
    logic [SP_W-1:0]  sp_cur, sp_inc, sp_dec, sp_next;
    logic             in_exec, is_call, is_pop, full, empty;
    logic             push_ok, pop_ok;

    // Sequence the three command phases and capture the command on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_SAVE;
            cur_q  <= '0;
            tgt_q  <= '0;
            live_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    state  <= ST_READ;
                    op_q   <= op_e'(cmd_op);
                    cur_q  <= cur_ctx;
                    tgt_q  <= tgt_ctx;
                    live_q <= live_regs;
                end
                ST_READ: state <= ST_EXEC;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the execute phase.
    always_comb begin
        in_exec = (state == ST_EXEC);
        is_call = (op_q == OP_CALL);
        is_pop  = (op_q == OP_RET) || (op_q == OP_IRET);
        full    = (sp_cur == SP_W'(DEPTH));
        empty   = (sp_cur == '0);
        push_ok = in_exec && is_call && !full;
        pop_ok  = in_exec && is_pop && !empty;
        sp_inc  = sp_cur + SP_W'(1);
        sp_dec  = sp_cur - SP_W'(1);
        sp_next = is_call ? sp_inc : sp_dec;
    end

    assign busy = (state != ST_IDLE);

    ctxstk_sp_table #(.CTX_W(CTX_W), .DEPTH(DEPTH), .SP_W(SP_W)) u_sp (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_ctx (cur_q),
        .rd_sp  (sp_cur),
        .we     (push_ok || pop_ok),
        .wr_ctx (cur_q),
        .wr_sp  (sp_next)
    );

    ctxstk_ram #(.AW(SAW), .DW(REG_W)) u_stack (
        .clk   (clk),
        .we    (push_ok),
        .waddr ({cur_q, sp_cur[PTR_W-1:0]}),
        .wdata (live_q),
        .re    (state == ST_READ),
        .raddr ({cur_q, sp_dec[PTR_W-1:0]}),
        .rdata (stk_rd)
    );

    ctxstk_ie_force #(.CTX_W(CTX_W), .REG_W(REG_W), .IE_POS(IE_POS), .RT_LAST(RT_LAST)) u_ie (
        .ctx        (cur_q),
        .regs_in    (live_q),
        .regs_fixed (live_fixed)
    );

    ctxstk_ram #(.AW(CTX_W), .DW(REG_W)) u_ctxmem (
        .clk   (clk),
        .we    (in_exec && (op_q == OP_SAVE)),
        .waddr (cur_q),
        .wdata (live_fixed),
        .re    (state == ST_READ),
        .raddr (tgt_q),
        .rdata (ctx_rd)
    );

    // Register completion, result set and status pulses at the end of execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            regs_load <= 1'b0;
            regs_out  <= '0;
            irq_ret   <= 1'b0;
            ovf       <= 1'b0;
            unf       <= 1'b0;
        end else begin
            done      <= in_exec;
            regs_load <= push_ok || pop_ok;
            irq_ret   <= pop_ok && (op_q == OP_IRET);
            ovf       <= in_exec && is_call && full;
            unf       <= in_exec && is_pop && empty;
            if (push_ok)     regs_out <= ctx_rd;
            else if (pop_ok) regs_out <= stk_rd;
        end
    end

    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_flags_in_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_load || irq_ret || ovf || unf) |-> done);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> !regs_load);
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> (!regs_load && !irq_ret));
    p_iret_pops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ret |-> regs_load);
endmodule

// File: tb/ctx_regstack_tb.sv
`timescale 1ns/1ps
module ctx_regstack_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [7:0]  cur_ctx = '0, tgt_ctx = '0;
    logic [15:0] live_regs = '0;
    logic        busy, done, regs_load, irq_ret, ovf, unf;
    logic [15:0] regs_out;

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    logic s_b1, s_b2, s_busy, s_done, s_load, s_irq, s_ovf, s_unf, s_after;
    logic [15:0] s_out;

    always #2 clk = ~clk;

    ctx_regstack u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cur_ctx(cur_ctx), .tgt_ctx(tgt_ctx), .live_regs(live_regs),
        .busy(busy), .done(done), .regs_load(regs_load), .regs_out(regs_out),
        .irq_ret(irq_ret), .ovf(ovf), .unf(unf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected stored set for a save, from the forcing rule.
    function automatic logic [15:0] forced(input int ctx, input logic [15:0] v);
        if (ctx == 0) return v;
        if (ctx <= 3) return v & 16'hFFFE;
        return v | 16'h0001;
    endfunction

    // Issue one command and sample the done cycle.
    task automatic run(input logic [1:0] op, input int cur, input int tgt, input logic [15:0] live);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cur_ctx = cur[7:0]; tgt_ctx = tgt[7:0]; live_regs = live;
        @(negedge clk);
        cmd_valid = 1'b0; s_b1 = busy;
        @(negedge clk);
        s_b2 = busy;
        @(negedge clk);
        s_busy = busy; s_done = done; s_load = regs_load; s_out = regs_out;
        s_irq = irq_ret; s_ovf = ovf; s_unf = unf;
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 flags", {regs_load, irq_ret, ovf, unf}, 0);
        run(2'b10, 5, 0, 16'h0);
        chk("R1/R8 empty after reset unf", s_unf, 1);
        chk("R8 no load", s_load, 0);
        run(2'b11, 200, 0, 16'h0);
        chk("R8 iret on empty unf", s_unf, 1);
        chk("R8 iret on empty no irq_ret", s_irq, 0);
    endtask

    task automatic t_latency;
        run(2'b00, 20, 0, 16'h1234);
        chk("R2 busy cycle1", s_b1, 1);
        chk("R2 busy cycle2", s_b2, 1);
        chk("R2 busy low at done", s_busy, 0);
        chk("R2 done", s_done, 1);
        @(negedge clk);
        chk("R2 done one cycle", done, 0);
    endtask

    task automatic readback(input int ctx, input logic [15:0] live, input string tag);
        run(2'b00, ctx, 0, live);
        run(2'b01, 40, ctx, 16'hC0DE);
        chk({tag, " R5 load"}, s_load, 1);
        chk({tag, " R4 stored set"}, s_out, forced(ctx, live));
        run(2'b10, 40, 0, 16'h0);
        chk({tag, " R6 pop restores caller"}, s_out, 16'hC0DE);
    endtask

    task automatic t_save_force;
        readback(1, 16'hABCD, "ctx1");
        readback(3, 16'h5555, "ctx3");
        readback(4, 16'h2222, "ctx4");
        readback(0, 16'h7777, "ctx0 ie1");
        readback(0, 16'h7776, "ctx0 ie0");
        readback(255, 16'h8000, "ctx255");
    endtask

    task automatic t_lifo_overflow;
        run(2'b00, 4, 0, 16'h4444);
        for (int i = 0; i < 8; i++) begin
            run(2'b01, 50, 4, 16'h0100 + 16'(i));
            chk("R5 push load", s_load, 1);
            chk("R7 no ovf below full", s_ovf, 0);
        end
        run(2'b01, 50, 4, 16'hDEAD);
        chk("R7 ovf when full", s_ovf, 1);
        chk("R7 refused no load", s_load, 0);
        for (int i = 7; i >= 0; i--) begin
            run(2'b10, 50, 0, 16'h0);
            chk("R6/R7 LIFO pop", s_out, 16'h0100 + 16'(i));
            chk("R9 return no irq_ret", s_irq, 0);
        end
        run(2'b10, 50, 0, 16'h0);
        chk("R8 unf after drain", s_unf, 1);
    endtask

    task automatic t_irqret;
        run(2'b01, 60, 4, 16'hBEEF);
        chk("R9 call no irq_ret", s_irq, 0);
        run(2'b11, 60, 0, 16'h0);
        chk("R9 iret pop value", s_out, 16'hBEEF);
        chk("R9 iret load", s_load, 1);
        chk("R9 iret pulse", s_irq, 1);
        run(2'b11, 60, 0, 16'h0);
        chk("R9/R8 iret empty no irq", s_irq, 0);
        chk("R8 iret empty unf", s_unf, 1);
    endtask

    task automatic t_indep;
        run(2'b01, 70, 4, 16'hAAA0);
        run(2'b01, 71, 4, 16'hBBB0);
        run(2'b01, 71, 4, 16'hBBB1);
        run(2'b10, 70, 0, 16'h0);
        chk("R10 ctx70 own entry", s_out, 16'hAAA0);
        run(2'b10, 71, 0, 16'h0);
        chk("R10 ctx71 top", s_out, 16'hBBB1);
        run(2'b10, 70, 0, 16'h0);
        chk("R10 ctx70 empty", s_unf, 1);
        run(2'b10, 71, 0, 16'h0);
        chk("R10 ctx71 second", s_out, 16'hBBB0);
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00; cur_ctx = 8'd30; live_regs = 16'h3330;
        @(negedge clk);
        cmd_op = 2'b01; cur_ctx = 8'd9; tgt_ctx = 8'd4; live_regs = 16'h9999;
        @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R3 original done", done, 1);
        chk("R3 no load from ignored call", regs_load, 0);
        @(negedge clk);
        s_after = busy;
        chk("R3 nothing accepted", s_after, 0);
        chk("R3 no second done", done, 0);
        run(2'b10, 9, 0, 16'h0);
        chk("R3 ignored call pushed nothing", s_unf, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_latency;
        t_save_force;
        t_lifo_overflow;
        t_irqret;
        t_indep;
        t_busy_ignore;
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule